// File: doc/BRIEF.md
# Resynchronizable Integer Clock Divider

This block divides an input sample clock by a programmable integer ratio from 1 to 8. It runs entirely on the input clock. It produces a one-cycle clock-enable pulse once per divided period, and a divided clock level whose duty cycle is shaped as the ratio allows. A realignment input lets several dividers that share the same realignment line restart their counters together, so that they keep a common sampling phase.

A small register write port holds the ratio and the realignment mode. In continuous mode, every rising edge of the realignment input restarts the counter. In one-shot mode, only the first such edge after a register write restarts it, and later edges are ignored until the register is written again. A separate stabilizer-enable input says whether duty-cycle correction is available. Ratios that are not a power of two need that correction, and the block raises a configuration-error flag when one of them is programmed while correction is off. A ratio change waits for the end of the current divided period, so the block never emits a shortened period.

Top module: `clkdiv_realign`

## Requirements
- R1: The configuration word `cfg_wdata` carries the ratio minus one in bits [2:0], so 3'b000 selects divide-by-1 and 3'b111 selects divide-by-8. It carries the mode in bit 3: 0 is continuous, 1 is one-shot. With no realignment, `div_ce` is high for exactly one cycle in every N cycles.
- R2: `cfg_err` is high exactly when the programmed ratio is 3, 5, 6 or 7 and `stab_en` is low. It is never high for ratios 1, 2, 4 or 8.
- R3: A rising edge of `sync_in` is taken at a clock edge. If it is honoured, that edge restarts the counter. `div_ce` is then high at the Nth following clock edge and every N edges after that.
- R4: In continuous mode, every rising edge of `sync_in` is honoured. A level held high counts as a single edge.
- R5: In one-shot mode, only the first rising edge of `sync_in` after a register write is honoured, and later edges leave the output phase unchanged. Every write re-arms the block. If a rising edge and a write fall on the same clock edge, the edge is judged under the old settings and the block ends up armed.
- R6: `div_clk` is high for the first H cycles of each divided period and low for the rest. H is N/2 for even N and 1 for N=1. For odd N above 1, H is (N+1)/2 when the period began with `stab_en` high, and (N-1)/2 otherwise.
- R7: A newly written ratio, and the `stab_en` level, take effect only at the next period wrap or the next honoured realignment, whichever comes first.
- R8: `armed` is high exactly when the block is in one-shot mode and no realignment has been honoured since the last write.
- R9: After reset, the ratio is 1, the mode is continuous, `armed` is low, `cfg_err` is low, and `div_ce` and `div_clk` are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 4 | Configuration word: one-shot bit 3, ratio minus one in bits [2:0] |
| stab_en | input | 1 | Duty-cycle stabilizer enabled |
| sync_in | input | 1 | Realignment request, acted on at its rising edge |
| div_ce | output | 1 | One-cycle enable, once per divided period |
| div_clk | output | 1 | Divided clock level |
| cfg_err | output | 1 | Ratio needs stabilization but it is disabled |
| armed | output | 1 | One-shot mode is armed |

## Verification
The assertions rely on three things about the inputs: `cfg_we` is low while reset is held, `sync_in` and `stab_en` change only away from the active clock edge, and `cfg_wdata` is valid whenever `cfg_we` is high. The stimulus meets all three by driving every input one nanosecond after a rising edge and keeping the write strobe low throughout reset. Within those limits it places realignment pulses at many counter phases and holds `sync_in` high for long stretches. It also writes the register on the same edge as a realignment edge, and changes the ratio in the middle of a period, so that every path by which the counter can return to zero is exercised.

// File: rtl/clkdiv_pkg.sv
// Package: shared widths, the configuration record and ratio helpers
// for the resynchronizable clock divider.
// Assumes ratios are stored as (ratio - 1) in RATIO_W bits.
package clkdiv_pkg;

    localparam int RATIO_W = 3;
    localparam int CFG_W   = RATIO_W + 1;
    localparam int LEN_W   = RATIO_W + 1;

    typedef struct packed {
        logic               one_shot;
        logic [RATIO_W-1:0] ratio_m1;
    } cfg_t;

    // True when ratio (m1 + 1) is not a power of two
    function automatic logic needs_stab(input logic [RATIO_W-1:0] m1);
        logic [LEN_W-1:0] n;
        n = LEN_W'(m1) + LEN_W'(1);
        return (n & (n - LEN_W'(1))) != '0;
    endfunction

    // Number of high cycles of the divided clock for ratio (m1 + 1)
    function automatic logic [LEN_W-1:0] high_len(input logic [RATIO_W-1:0] m1,
                                                  input logic stab);
        logic [LEN_W-1:0] n;
        n = LEN_W'(m1) + LEN_W'(1);
        if (n == LEN_W'(1))
            return LEN_W'(1);
        else if (n[0] && stab)
            return (n + LEN_W'(1)) >> 1;
        else
            return n >> 1;
    endfunction

endpackage

// File: rtl/clkdiv_cfg.sv
// Module: configuration register and one-shot arm flag.
// Holds the ratio and mode written through the write port. A write
// re-arms; an honoured realignment in one-shot mode disarms. A write
// wins over a disarm on the same edge.
module clkdiv_cfg
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             honour,
    output cfg_t             cfg,
    output logic             armed_q
);

    // Register the configuration word on a write
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= '0;
        else if (we)
            cfg <= cfg_t'(wdata);
    end

    // Track whether a one-shot realignment is still pending
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b1;
        else if (we)
            armed_q <= 1'b1;
        else if (honour && cfg.one_shot)
            armed_q <= 1'b0;
    end

endmodule

// File: rtl/clkdiv_sync.sv
// Module: realignment edge detector and gate.
// Detects a rising edge of the realignment input against its value at
// the previous clock edge. It passes the edge on when the mode is
// continuous, or when the mode is one-shot and the block is armed.
// Assumes sync_in is synchronous to clk.
module clkdiv_sync
    import clkdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic one_shot,
    input  logic armed_q,
    output logic honour
);

    logic sync_prev;
    logic rise;

    // Remember the last sampled level of the realignment input
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_prev <= 1'b0;
        else
            sync_prev <= sync_in;
    end

    // Qualify the rising edge with the current mode and arm state
    always_comb begin
        rise   = sync_in && !sync_prev;
        honour = rise && (!one_shot || armed_q);
    end

endmodule

// File: rtl/clkdiv_core.sv
// Module: period counter and output shaping.
// Counts 0..N-1 with the active ratio. The ratio and stabilizer level
// are loaded from the programmed values only at a wrap or at an
// honoured realignment, so no period is ever cut short.
module clkdiv_core
    import clkdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_m1,
    input  logic               stab_en,
    input  logic               honour,
    output logic               div_ce,
    output logic               div_clk
);

    logic [RATIO_W-1:0] cnt;
    logic [RATIO_W-1:0] act_m1;
    logic               act_stab;
    logic               wrap;
    logic [LEN_W-1:0]   hi_len;

    // Decode the end of a period and the high time of the current one
    always_comb begin
        wrap   = (cnt == act_m1);
        hi_len = high_len(act_m1, act_stab);
    end

    // Advance the counter; restart and load new settings at wrap or realign
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            act_m1   <= '0;
            act_stab <= 1'b0;
        end else if (honour || wrap) begin
            cnt      <= '0;
            act_m1   <= ratio_m1;
            act_stab <= stab_en;
        end else begin
            cnt      <= cnt + RATIO_W'(1);
        end
    end

    // Drive the enable pulse and the divided clock level
    always_comb begin
        div_ce  = wrap;
        div_clk = (LEN_W'(cnt) < hi_len);
    end

endmodule

// File: rtl/clkdiv_realign.sv
// Module: top of the resynchronizable integer clock divider.
// Ties the configuration register, the realignment gate and the period
// counter together and flags ratios that need stabilization while it is
// off. All logic runs on the input clock.
module clkdiv_realign
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             stab_en,
    input  logic             sync_in,
    output logic             div_ce,
    output logic             div_clk,
    output logic             cfg_err,
    output logic             armed
);

    cfg_t cfg;
    logic armed_q;
    logic honour;

    clkdiv_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .honour  (honour),
        .cfg     (cfg),
        .armed_q (armed_q)
    );

    clkdiv_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (sync_in),
        .one_shot (cfg.one_shot),
        .armed_q  (armed_q),
        .honour   (honour)
    );

    clkdiv_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ratio_m1 (cfg.ratio_m1),
        .stab_en  (stab_en),
        .honour   (honour),
        .div_ce   (div_ce),
        .div_clk  (div_clk)
    );

    // Report status: configuration error and visible arm state
    always_comb begin
        cfg_err = needs_stab(cfg.ratio_m1) && !stab_en;
        armed   = cfg.one_shot && armed_q;
    end

endmodule

// File: rtl/clkdiv_realign_chk.sv
// Module: port-level property checker for clkdiv_realign.
// Assumes cfg_we is low during reset and inputs change away from edges.
module clkdiv_realign_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_we,
    input logic mode_bit,
    input logic stab_en,
    input logic sync_in,
    input logic div_ce,
    input logic div_clk,
    input logic cfg_err,
    input logic armed
);

    AST_ERR_NEEDS_STAB_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !stab_en); // R2

    AST_DISARM_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(armed) && $past(rst_n) && !$past(cfg_we)) |-> $past(sync_in)); // R5

    AST_WRITE_SETS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_we) && $past(rst_n)) |-> (armed == $past(mode_bit))); // R8

    AST_CLK_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(div_clk) && $past(rst_n)) |-> ($past(div_ce) || $past(sync_in))); // R3

    AST_CLK_HIGH_AFTER_CE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(div_ce) && $past(rst_n)) |-> div_clk); // R6

endmodule

bind clkdiv_realign clkdiv_realign_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .mode_bit (cfg_wdata[clkdiv_pkg::RATIO_W]),
    .stab_en  (stab_en),
    .sync_in  (sync_in),
    .div_ce   (div_ce),
    .div_clk  (div_clk),
    .cfg_err  (cfg_err),
    .armed    (armed)
);

// File: tb/clkdiv_realign_tb.sv
`timescale 1ns/1ps
module clkdiv_realign_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_wdata = '0;
    logic       stab_en = 1'b0;
    logic       sync_in = 1'b0;
    logic       div_ce, div_clk, cfg_err, armed;

    int n_chk = 0;
    int n_fail = 0;
    bit go = 0;
    bit done = 0;

    // behavioural reference state
    int m_cnt = 0, m_act = 1, m_st = 0, m_reg = 1, m_mode = 0, m_arm = 1, m_prev = 0;

    always #2.5 clk = ~clk;

    clkdiv_realign u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .stab_en(stab_en), .sync_in(sync_in), .div_ce(div_ce),
        .div_clk(div_clk), .cfg_err(cfg_err), .armed(armed)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model advanced on every edge from the spec
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_act = 1; m_st = 0; m_reg = 1; m_mode = 0; m_arm = 1; m_prev = 0;
        end else begin
            bit hon;
            hon = sync_in && !m_prev && (m_mode == 0 || m_arm == 1);
            if (hon || m_cnt == m_act - 1) begin
                m_cnt = 0; m_act = m_reg; m_st = stab_en;
            end else m_cnt++;
            if (cfg_we) begin
                m_reg = cfg_wdata[2:0] + 1; m_mode = cfg_wdata[3]; m_arm = 1;
            end else if (hon && m_mode == 1) m_arm = 0;
            m_prev = sync_in;
        end
        go = 1;
    end

    // compare outputs every cycle away from the edge
    always @(negedge clk) begin
        if (go && !done) begin
            int hi, e_ce, e_clk, e_err, e_arm;
            hi = (m_act == 1) ? 1 : ((m_act % 2 == 1 && m_st == 1) ? (m_act + 1) / 2 : m_act / 2);
            e_ce  = (m_cnt == m_act - 1);
            e_clk = (m_cnt < hi);
            e_err = (m_reg == 3 || m_reg == 5 || m_reg == 6 || m_reg == 7) && !stab_en;
            e_arm = (m_mode == 1 && m_arm == 1);
            chk(div_ce == e_ce,   "R1 R3 R7 div_ce",  div_ce,  e_ce);
            chk(div_clk == e_clk, "R6 div_clk",       div_clk, e_clk);
            chk(cfg_err == e_err, "R2 cfg_err",       cfg_err, e_err);
            chk(armed == e_arm,   "R5 R8 armed",      armed,   e_arm);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input int ratio, input bit one_shot);
        cfg_we = 1'b1; cfg_wdata = {one_shot, 3'(ratio - 1)};
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic sync_pulse(input int len);
        sync_in = 1'b1; step(len);
        sync_in = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        step(3);
        // R9: reset state seen at the ports
        chk(div_ce == 1 && div_clk == 1, "R9 reset outputs", {div_ce, div_clk}, 3);
        chk(cfg_err == 0 && armed == 0, "R9 reset status", {cfg_err, armed}, 0);
        rst_n = 1'b1;
        step(6);
        // R1 R6: every ratio with stabilization on
        stab_en = 1'b1;
        for (int r = 1; r <= 8; r++) begin wr(r, 0); step(3 * r + 5); end
        // R4: continuous realignment at assorted phases, held level counts once
        wr(5, 0); step(7);
        sync_pulse(1); step(3);
        sync_pulse(1); step(1);
        sync_pulse(12); step(9);
        wr(6, 0); step(4);
        for (int k = 0; k < 6; k++) begin sync_pulse(1); step(k + 1); end
        // R5 R8: one-shot arm, ignore, re-arm, write on a sync edge
        wr(4, 1); step(3);
        sync_pulse(1); step(6);
        sync_pulse(1); step(5);
        sync_pulse(3); step(3);
        wr(7, 1); step(2);
        sync_pulse(1); step(10);
        cfg_we = 1'b1; cfg_wdata = 4'b1010; sync_in = 1'b1; step(1);
        cfg_we = 1'b0; sync_in = 1'b0; step(5);
        sync_pulse(1); step(12);
        wr(5, 0); step(4);
        // R2 R6: stabilization off across all ratios, and toggled live
        stab_en = 1'b0;
        for (int r = 1; r <= 8; r++) begin wr(r, 0); step(2 * r + 4); end
        for (int r = 3; r <= 7; r++) begin wr(r, 0); stab_en = 1'b1; step(r + 2); stab_en = 1'b0; step(r + 2); end
        // R7: ratio change in mid-period, then a realignment before the wrap
        stab_en = 1'b1;
        wr(8, 0); step(12);
        wr(3, 0); step(20);
        wr(8, 0); step(9);
        wr(2, 0); step(2); sync_pulse(1); step(10);
        wr(7, 1); step(3); wr(7, 0); step(10);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule